// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block decides which of several interrupt sources, or a reset request, a small 8-bit processor core should service next. It produces a single vectored request that carries a program-memory vector address. Slot 0 is reserved for reset. Source `k` (request bit `k`) owns slot `k+1`, so external interrupt 0 sits directly below reset in both address and priority. A lower slot wins.

The block owns the global interrupt enable. Software sets it or clears it with strobes, and a return-from-interrupt strobe sets it again. The block clears it whenever it takes a request. Interrupt vectors can be moved to the boot-section start by a select bit. The reset vector is moved by a separate configuration bit. Two lock inputs block interrupts while code runs outside the section that holds the active interrupt table.

All decisions are made on a rising clock edge from the inputs sampled there. The outputs are registered, so they appear in the cycle after that edge.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released with no stimulus, `take`, `gie`, `vec_addr`, `ack_idx` and `ack` are all zero.
- R2: An interrupt source is taken only if its request bit, its enable bit and `gie` are all one at the sampling edge. If the request is not taken, `take` stays 0.
- R3: When several sources qualify, the one with the lowest slot wins. Request bit `k` maps to slot `k+1`, and `ack_idx` reports that slot.
- R4: An interrupt vector address equals base + slot × `STRIDE`. The base is `BOOT_BASE` when `ivec_boot` is 1 and 0 otherwise.
- R5: A reset vector address is `BOOT_BASE` when `rvec_boot` is 1 and 0 otherwise, whatever the value of `ivec_boot`.
- R6: The boot section is `pc >= BOOT_BASE`. Interrupts are blocked in two cases: when `ivec_boot`=1, `pc` is outside the boot section and `lock_app`=1; and when `ivec_boot`=0, `pc` is inside the boot section and `lock_boot`=1. A lock that does not match the active table has no effect.
- R7: A take asserts `take` for one cycle and pulses exactly one bit of `ack`, the winning request bit. In the same cycle `gie` reads 0. At all other times `ack` is zero.
- R8: `gie_set` or `reti` makes `gie` 1 in the next cycle. `gie_clr` makes it 0 and wins over both.
- R9: `rst_req` is taken whatever the values of `gie`, the enables and the locks. It overrides any pending interrupt, reports slot 0 with `ack` zero, and forces `gie` to 0.
- R10: `vec_addr` and `ack_idx` hold the values of the last take until the next take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | Reset source request, unmaskable |
| irq_req | input | NSRC | Interrupt request per source |
| irq_en | input | NSRC | Enable bit per source |
| pc | input | PC_W | Current program counter (word address) |
| ivec_boot | input | 1 | Interrupt table lives at the boot-section start |
| rvec_boot | input | 1 | Reset vector lives at the boot-section start |
| lock_app | input | 1 | Blocks interrupts in the application section when the table is in boot |
| lock_boot | input | 1 | Blocks interrupts in the boot section when the table is at zero |
| gie_set | input | 1 | Software strobe that sets global enable |
| gie_clr | input | 1 | Software strobe that clears global enable |
| reti | input | 1 | Return strobe that sets global enable |
| take | output | 1 | One-cycle vectored request to the core |
| vec_addr | output | PC_W | Vector address of the taken request |
| ack_idx | output | IDX_W | Slot taken (0 = reset) |
| ack | output | NSRC | One-hot acknowledge to the winning source |
| gie | output | 1 | Global interrupt enable state |

## Verification
The bound checker watches every cycle for five rules. No interrupt is taken without global enable or while a lock blocks it. `ack` is one-hot and matches `ack_idx`. The vector address agrees with the base chosen at the deciding edge. A reset request always yields slot 0 with enable cleared. The enable strobes land as specified. Winner selection among competing sources can only be shown by the bench scenarios. So can the exact addresses for specific patterns, the independence of the two relocation bits, and the holding of the vector between takes. Each of these is checked against values worked out from the requirements.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NSRC      = 8,
  parameter int PC_W      = 16,
  parameter int BOOT_BASE = 'h7000,
  parameter int STRIDE    = 2,
  localparam int IDX_W    = $clog2(NSRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_req,
  input  logic [NSRC-1:0]  irq_req,
  input  logic [NSRC-1:0]  irq_en,
  input  logic [PC_W-1:0]  pc,
  input  logic             ivec_boot,
  input  logic             rvec_boot,
  input  logic             lock_app,
  input  logic             lock_boot,
  input  logic             gie_set,
  input  logic             gie_clr,
  input  logic             reti,
  output logic             take,
  output logic [PC_W-1:0]  vec_addr,
  output logic [IDX_W-1:0] ack_idx,
  output logic [NSRC-1:0]  ack,
  output logic             gie
);

  localparam logic [PC_W-1:0] BOOT_A = PC_W'(BOOT_BASE);
  localparam logic [PC_W-1:0] STEP   = PC_W'(STRIDE);

  logic             in_boot, locked, any_live;
  logic [NSRC-1:0]  live, first;
  logic [IDX_W-1:0] win;
  logic [PC_W-1:0]  ivec_base, rvec_base, win_addr;

  assign in_boot   = pc >= BOOT_A;
  assign locked    = ivec_boot ? (!in_boot && lock_app) : (in_boot && lock_boot);
  assign live      = irq_req & irq_en & {NSRC{gie && !locked}};
  assign any_live  = |live;
  assign first     = live & (~live + NSRC'(1));
  assign ivec_base = ivec_boot ? BOOT_A : '0;
  assign rvec_base = rvec_boot ? BOOT_A : '0;

  always_comb begin
    win = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (live[i]) win = IDX_W'(i + 1);
  end

  assign win_addr = ivec_base + PC_W'(win) * STEP;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take     <= 1'b0;
      vec_addr <= '0;
      ack_idx  <= '0;
      ack      <= '0;
      gie      <= 1'b0;
    end else if (rst_req) begin
      take     <= 1'b1;
      vec_addr <= rvec_base;
      ack_idx  <= '0;
      ack      <= '0;
      gie      <= 1'b0;
    end else if (any_live) begin
      take     <= 1'b1;
      vec_addr <= win_addr;
      ack_idx  <= win;
      ack      <= first;
      gie      <= 1'b0;
    end else begin
      take <= 1'b0;
      ack  <= '0;
      if (gie_clr)              gie <= 1'b0;
      else if (gie_set || reti) gie <= 1'b1;
    end
  end

endmodule

module irq_vector_ctrl_chk #(
  parameter int NSRC      = 8,
  parameter int PC_W      = 16,
  parameter int BOOT_BASE = 'h7000,
  parameter int STRIDE    = 2,
  localparam int IDX_W    = $clog2(NSRC + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_req,
  input logic [NSRC-1:0]  irq_req,
  input logic [NSRC-1:0]  irq_en,
  input logic [PC_W-1:0]  pc,
  input logic             ivec_boot,
  input logic             rvec_boot,
  input logic             lock_app,
  input logic             lock_boot,
  input logic             gie_set,
  input logic             gie_clr,
  input logic             reti,
  input logic             take,
  input logic [PC_W-1:0]  vec_addr,
  input logic [IDX_W-1:0] ack_idx,
  input logic [NSRC-1:0]  ack,
  input logic             gie
);

  localparam logic [PC_W-1:0] BA = PC_W'(BOOT_BASE);

  logic blk;
  assign blk = ivec_boot ? (pc < BA && lock_app) : (pc >= BA && lock_boot);

  assert_no_take_without_gie_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req && (!gie || ((irq_req & irq_en) == '0))) |=> !take);

  assert_lock_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req && blk) |=> !take);

  assert_ack_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack) && (!take -> ack == '0) && (take -> !gie));

  assert_ack_matches_idx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ack_idx != '0) |-> ack == (NSRC'(1) << (ack_idx - 1'b1)));

  assert_irq_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ack_idx != '0) |->
      vec_addr == ($past(ivec_boot) ? BA : '0) + PC_W'(ack_idx) * PC_W'(STRIDE));

  assert_reset_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> take && ack_idx == '0 && ack == '0 && !gie);

  assert_reset_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> vec_addr == ($past(rvec_boot) ? BA : '0));

  assert_gie_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_req && !gie && !gie_clr && (gie_set || reti)) |=> gie);

  assert_gie_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gie_clr |=> !gie);

endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .NSRC(NSRC), .PC_W(PC_W), .BOOT_BASE(BOOT_BASE), .STRIDE(STRIDE)
) u_chk (.*);

// File: tb/irq_vector_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vector_ctrl_bench;
  localparam int NSRC = 8, PC_W = 16, BOOT = 'h7000, STRIDE = 2;
  localparam int IDX_W = $clog2(NSRC + 1);

  logic clk = 0, rst_n = 0, rst_req = 0;
  logic [NSRC-1:0] irq_req = '0, irq_en = '0;
  logic [PC_W-1:0] pc = '0;
  logic ivec_boot = 0, rvec_boot = 0, lock_app = 0, lock_boot = 0;
  logic gie_set = 0, gie_clr = 0, reti = 0;
  logic take, gie;
  logic [PC_W-1:0] vec_addr;
  logic [IDX_W-1:0] ack_idx;
  logic [NSRC-1:0] ack;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_vector_ctrl #(.NSRC(NSRC), .PC_W(PC_W), .BOOT_BASE(BOOT), .STRIDE(STRIDE)) u_irq_vector_ctrl (
    .clk, .rst_n, .rst_req, .irq_req, .irq_en, .pc, .ivec_boot, .rvec_boot,
    .lock_app, .lock_boot, .gie_set, .gie_clr, .reti,
    .take, .vec_addr, .ack_idx, .ack, .gie);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic expect_take(input string req, input int idx, input int addr, input int ackv);
    chk(take == 1, req, "take", take, 1);
    chk(ack_idx == idx, req, "ack_idx", ack_idx, idx);
    chk(vec_addr == addr, req, "vec_addr", vec_addr, addr);
    chk(ack == ackv, req, "ack", ack, ackv);
    chk(gie == 0, req, "gie after take", gie, 0);
  endtask

  task automatic enable_gie();
    gie_set = 1; step(); gie_set = 0;
    chk(gie == 1, "R8", "gie after set", gie, 1);
  endtask

  task automatic idle_clear();
    irq_req = '0; step();
    chk(take == 0 && ack == '0, "R7", "take/ack after pulse", {take, ack}, 0);
  endtask

  task automatic t_reset();
    chk({take, gie, vec_addr, ack_idx, ack} == '0, "R1", "reset state", {take, gie, vec_addr, ack_idx, ack}, 0);
    rst_n = 1; step();
    chk({take, gie, vec_addr, ack_idx, ack} == '0, "R1", "post release", {take, gie, vec_addr, ack_idx, ack}, 0);
  endtask

  task automatic t_gating();
    irq_req = 8'h08; irq_en = 8'h08; step();
    chk(take == 0, "R2", "no take gie=0", take, 0);
    irq_req = '0; enable_gie();
    irq_req = 8'h08; irq_en = 8'h00; step();
    chk(take == 0, "R2", "no take en=0", take, 0);
    irq_en = 8'h08; step();
    expect_take("R2", 4, 8, 8'h08);
    irq_req = '0; step();
    chk(take == 0 && ack == '0, "R7", "single pulse", {take, ack}, 0);
    chk(vec_addr == 8 && ack_idx == 4, "R10", "hold vector", vec_addr, 8);
  endtask

  task automatic t_priority();
    irq_en = '1; enable_gie();
    irq_req = 8'hA4; step();
    expect_take("R3", 3, 6, 8'h04);
    idle_clear();
    reti = 1; step(); reti = 0;
    chk(gie == 1, "R8", "gie after reti", gie, 1);
    irq_req = 8'hFF; step();
    expect_take("R3", 1, 2, 8'h01);
    idle_clear();
  endtask

  task automatic t_relocate();
    ivec_boot = 1; pc = 16'(BOOT + 'h40); enable_gie();
    irq_req = 8'h60; step();
    expect_take("R4", 6, BOOT + 12, 8'h20);
    idle_clear();
    ivec_boot = 0; pc = 0;
  endtask

  task automatic t_lock();
    ivec_boot = 1; pc = 16'h0100; lock_app = 1; enable_gie();
    irq_req = 8'h02; step();
    chk(take == 0, "R6", "app lock blocks", take, 0);
    lock_app = 0; step();
    expect_take("R6", 2, BOOT + 4, 8'h02);
    idle_clear();
    ivec_boot = 0; pc = 16'(BOOT + 4); lock_boot = 1; enable_gie();
    irq_req = 8'h01; step();
    chk(take == 0, "R6", "boot lock blocks", take, 0);
    pc = 16'h0010; step();
    expect_take("R6", 1, 2, 8'h01);
    idle_clear();
    lock_boot = 0; lock_app = 1; enable_gie();
    irq_req = 8'h10; step();
    expect_take("R6", 5, 10, 8'h10);
    idle_clear();
    lock_app = 0;
  endtask

  task automatic t_reset_source();
    rvec_boot = 1; ivec_boot = 0; rst_req = 1; step(); rst_req = 0;
    expect_take("R5", 0, BOOT, 0);
    rvec_boot = 0; ivec_boot = 1; rst_req = 1; step(); rst_req = 0;
    expect_take("R5", 0, 0, 0);
    ivec_boot = 0; enable_gie();
    irq_req = 8'h01; rst_req = 1; step(); rst_req = 0;
    expect_take("R9", 0, 0, 0);
    irq_req = '0; step();
  endtask

  task automatic t_gie_ctrl();
    gie_set = 1; gie_clr = 1; step(); gie_set = 0; gie_clr = 0;
    chk(gie == 0, "R8", "clr wins over set", gie, 0);
    reti = 1; step(); reti = 0;
    chk(gie == 1, "R8", "reti sets", gie, 1);
    gie_clr = 1; reti = 1; step(); gie_clr = 0; reti = 0;
    chk(gie == 0, "R8", "clr wins over reti", gie, 0);
  endtask

  initial begin
    #1;
    t_reset();
    t_gating();
    t_priority();
    t_relocate();
    t_lock();
    t_reset_source();
    t_gie_ctrl();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule